// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Timer

This block raises a sticky timeout flag at a fixed, programmable rate. Each cycle it gets a clock-enable tick from one of two sources: an internal reference or an external oscillator. A configuration bit chooses the source. A two-stage counter counts the selected ticks. The first stage is a binary prescaler sized by an exponent field, and the second stage is a modulus counter. When the last tick of a period arrives, the flag is set and the next period starts from zero on the same edge.

Software selects the period by writing an 8-bit rate value. Any write restarts the period from zero, even a write of the value already held. Software clears the flag by writing a 1 to it. The interrupt request is the flag gated by an enable input.

In stop mode the counter holds its count and does not advance. There is one exception: if pseudo-stop is active, the oscillator is the selected source and the oscillator-keep-running bit is set, counting continues.

Top module: `rti_timer`

## Requirements
- R1: The selected source decides which tick input is counted. osc_sel=1 counts osc_tick and osc_sel=0 counts irc_tick; the unselected tick input has no effect.
- R2: The rate value is split into two fields. rate_wdata[7:4] is an exponent E and rate_wdata[3:0] is a modulus M. The period is P = (M+1) × 2^(E+10) selected ticks. flag goes high on the edge that samples the P-th counted tick after the rate write edge.
- R3: An expiry starts the next period at once with no idle tick, so consecutive expiries are exactly P ticks apart.
- R4: While stop_mode=1 the count is frozen, unless the R5 condition holds. Counting resumes from the frozen value when stop_mode returns to 0.
- R5: Counting continues in stop mode only when pseudo_stop=1, osc_sel=1 and osc_pstop_run=1 all hold together.
- R6: irq is 1 exactly when irq_en=1 and flag=1.
- R7: A rate write (rate_we=1) discards the partial count, and the new period is measured from that write edge.
- R8: The flag clears when clr_we=1 with clr_wdata=1. clr_we=1 with clr_wdata=0 leaves the flag unchanged.
- R9: If an expiry and a clear fall on the same edge, the flag is set.
- R10: Synchronous reset (rst=1) clears the rate value, the counters and the flag. An exponent of 0, whether from reset or from a write, disables counting, so no expiry ever occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irc_tick | input | 1 | Internal reference clock-enable tick |
| osc_tick | input | 1 | External oscillator clock-enable tick |
| osc_sel | input | 1 | Source select: 1 = oscillator, 0 = internal reference |
| stop_mode | input | 1 | Stop mode is active |
| pseudo_stop | input | 1 | The stop in progress is a pseudo-stop |
| osc_pstop_run | input | 1 | The oscillator keeps running in pseudo-stop |
| rate_we | input | 1 | Rate register write strobe |
| rate_wdata | input | 8 | Rate value: exponent [7:4], modulus [3:0] |
| irq_en | input | 1 | Interrupt enable |
| clr_we | input | 1 | Flag write strobe |
| clr_wdata | input | 1 | Flag write data (1 clears the flag) |
| flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag clear that lands on exactly the edge of an expiry. The count is long and cannot be observed from outside. The bench reaches it by starting a period with a rate write, so that the expiry edge can be computed from the write edge. It then raises the clear strobe one cycle before that edge. The stop-mode freeze is checked in a similar way. The bench holds stop for a known number of cycles in the middle of a period and expects the expiry to move later by exactly that many cycles.

// File: rtl/rti_pkg.sv
package rti_pkg;

    localparam int EXP_W  = 4;
    localparam int MOD_W  = 4;
    localparam int RATE_W = EXP_W + MOD_W;

    typedef struct packed {
        logic [EXP_W-1:0] expo;
        logic [MOD_W-1:0] modv;
    } rate_t;

    typedef enum logic {
        SRC_IRC = 1'b0,
        SRC_OSC = 1'b1
    } src_e;

    // Width of the prescaler so that the largest exponent still fits.
    function automatic int pre_width(input int base_shift);
        return base_shift + (1 << EXP_W) - 1;
    endfunction

    function automatic logic rate_active(input rate_t r);
        return r.expo != '0;
    endfunction

endpackage

// File: rtl/rti_tick_sel.sv
module rti_tick_sel
    import rti_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic irc_tick,
    input  logic osc_tick,
    input  src_e src,
    input  logic stop_mode,
    input  logic pseudo_stop,
    input  logic osc_pstop_run,
    output logic count_en
);

    logic tick_raw;
    logic run_ok;

    always_comb begin
        tick_raw = (src == SRC_OSC) ? osc_tick : irc_tick;
        run_ok   = !stop_mode || (pseudo_stop && (src == SRC_OSC) && osc_pstop_run);
        count_en = tick_raw && run_ok;
    end

    assert_full_stop_halts_R4: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && !pseudo_stop) |-> !count_en);

    assert_pseudo_irc_halts_R5: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && src == SRC_IRC) |-> !count_en);

endmodule

// File: rtl/rti_prescaler.sv
module rti_prescaler
    import rti_pkg::*;
#(
    parameter int BASE_SHIFT = 10,
    localparam int PW = pre_width(BASE_SHIFT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             count_en,
    input  logic [EXP_W-1:0] expo,
    output logic             pulse
);

    logic [PW-1:0] cnt;
    logic [PW-1:0] mask;
    logic          active;

    always_comb begin
        active = (expo != '0);
        // (1 << PW) wraps to zero in PW bits, giving an all-ones mask.
        mask   = (PW'(1) << (int'(expo) + BASE_SHIFT)) - PW'(1);
        pulse  = active && count_en && !restart && ((cnt & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (count_en && active) begin
            cnt <= cnt + PW'(1);
        end
    end

    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !restart) |=> $stable(cnt));

    assert_zero_exp_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (expo == '0) |-> !pulse);

endmodule

// File: rtl/rti_modulus.sv
module rti_modulus
    import rti_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             pre_pulse,
    input  logic [MOD_W-1:0] modv,
    output logic             expire
);

    logic [MOD_W-1:0] cnt;

    always_comb begin
        expire = pre_pulse && (cnt == modv);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (pre_pulse) begin
            cnt <= expire ? '0 : cnt + MOD_W'(1);
        end
    end

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= modv);

    assert_expiry_wraps_R3: assert property (@(posedge clk) disable iff (rst)
        (expire && !restart) |=> (cnt == '0));

endmodule

// File: rtl/rti_flag.sv
module rti_flag (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic clr_we,
    input  logic clr_wdata,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    logic clr_hit;

    always_comb begin
        clr_hit = clr_we && clr_wdata;
        irq     = irq_en && flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (clr_hit) begin
            flag <= 1'b0;
        end
    end

    assert_expiry_wins_R9: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_hit) |=> flag);

    assert_clear_works_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && !expire) |=> !flag);

    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && irq_en));

endmodule

// File: rtl/rti_timer.sv
module rti_timer
    import rti_pkg::*;
#(
    parameter int BASE_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irc_tick,
    input  logic              osc_tick,
    input  logic              osc_sel,
    input  logic              stop_mode,
    input  logic              pseudo_stop,
    input  logic              osc_pstop_run,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic              irq_en,
    input  logic              clr_we,
    input  logic              clr_wdata,
    output logic              flag,
    output logic              irq
);

    rate_t rate_q;
    src_e  src;
    logic  count_en;
    logic  pre_pulse;
    logic  expire;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
        end else if (rate_we) begin
            rate_q <= rate_t'(rate_wdata);
        end
    end

    always_comb begin
        src = osc_sel ? SRC_OSC : SRC_IRC;
    end

    rti_tick_sel u_sel (
        .clk           (clk),
        .rst           (rst),
        .irc_tick      (irc_tick),
        .osc_tick      (osc_tick),
        .src           (src),
        .stop_mode     (stop_mode),
        .pseudo_stop   (pseudo_stop),
        .osc_pstop_run (osc_pstop_run),
        .count_en      (count_en)
    );

    rti_prescaler #(.BASE_SHIFT(BASE_SHIFT)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (rate_we),
        .count_en (count_en),
        .expo     (rate_q.expo),
        .pulse    (pre_pulse)
    );

    rti_modulus u_mod (
        .clk       (clk),
        .rst       (rst),
        .restart   (rate_we),
        .pre_pulse (pre_pulse),
        .modv      (rate_q.modv),
        .expire    (expire)
    );

    rti_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .irq_en    (irq_en),
        .flag      (flag),
        .irq       (irq)
    );

    assert_disabled_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
        (!rate_active(rate_q) && !rate_we) |=> !expire);

    assert_write_no_expiry_R7: assert property (@(posedge clk) disable iff (rst)
        rate_we |-> !expire);

endmodule

// File: tb/rti_timer_tb_top.sv
module rti_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       irc_tick, osc_tick, osc_sel;
    logic       stop_mode, pseudo_stop, osc_pstop_run;
    logic       rate_we;
    logic [7:0] rate_wdata;
    logic       irq_en, clr_we, clr_wdata;
    logic       flag, irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rti_timer dut_i (
        .clk           (clk),
        .rst           (rst),
        .irc_tick      (irc_tick),
        .osc_tick      (osc_tick),
        .osc_sel       (osc_sel),
        .stop_mode     (stop_mode),
        .pseudo_stop   (pseudo_stop),
        .osc_pstop_run (osc_pstop_run),
        .rate_we       (rate_we),
        .rate_wdata    (rate_wdata),
        .irq_en        (irq_en),
        .clr_we        (clr_we),
        .clr_wdata     (clr_wdata),
        .flag          (flag),
        .irq           (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_rate(input int e, input int m);
        rate_we    = 1'b1;
        rate_wdata = {4'(e), 4'(m)};
        step(1);
        rate_we    = 1'b0;
    endtask

    task automatic clear_flag();
        clr_we = 1'b1; clr_wdata = 1'b1;
        step(1);
        clr_we = 1'b0; clr_wdata = 1'b0;
    endtask

    task automatic default_cfg();
        irc_tick = 1'b1; osc_tick = 1'b0; osc_sel = 1'b0;
        stop_mode = 1'b0; pseudo_stop = 1'b0; osc_pstop_run = 1'b0;
        irq_en = 1'b0; clr_we = 1'b0; clr_wdata = 1'b0; rate_we = 1'b0;
    endtask

    // Called right after write_rate: flag must be low until cycle p, high at p.
    task automatic expect_expiry(input string req, input int p);
        int early = 0;
        for (int i = 1; i < p; i++) begin
            step(1);
            if (flag) early++;
        end
        check({req, " no early flag"}, early, 0);
        step(1);
        check({req, " flag at period end"}, flag, 1);
    endtask

    task automatic t_reset();
        default_cfg();
        rst = 1'b1; rate_wdata = '0;
        step(3);
        rst = 1'b0;
        check("R10 reset flag", flag, 0);
        check("R10 reset irq", irq, 0);
        begin
            int seen = 0;
            for (int i = 0; i < 3000; i++) begin
                step(1);
                if (flag) seen++;
            end
            check("R10 disabled after reset", seen, 0);
        end
    endtask

    task automatic t_period_restart(input int e, input int m);
        int p = (m + 1) * (1 << (e + 10));
        default_cfg();
        clear_flag();
        write_rate(e, m);
        expect_expiry("R2", p);
        clear_flag();
        check("R8 cleared", flag, 0);
        expect_expiry("R3", p - 1);
    endtask

    task automatic t_source();
        int seen = 0;
        default_cfg();
        osc_sel = 1'b1; osc_tick = 1'b0; irc_tick = 1'b1;
        clear_flag();
        write_rate(1, 0);
        for (int i = 0; i < 3000; i++) begin
            step(1);
            if (flag) seen++;
        end
        check("R1 unselected irc ignored", seen, 0);
        osc_tick = 1'b1; irc_tick = 1'b0;
        write_rate(1, 0);
        expect_expiry("R1 osc counted", 2048);
    endtask

    task automatic t_stop();
        default_cfg();
        clear_flag();
        write_rate(1, 0);
        step(500);
        stop_mode = 1'b1;
        step(1000);
        stop_mode = 1'b0;
        expect_expiry("R4 frozen in stop", 2048 - 500);
    endtask

    task automatic t_pseudo();
        int seen = 0;
        default_cfg();
        osc_sel = 1'b1; osc_tick = 1'b1; irc_tick = 1'b0;
        stop_mode = 1'b1; pseudo_stop = 1'b1; osc_pstop_run = 1'b1;
        clear_flag();
        write_rate(1, 0);
        expect_expiry("R5 runs in pseudo-stop", 2048);
        clear_flag();
        osc_pstop_run = 1'b0;
        write_rate(1, 0);
        for (int i = 0; i < 2148; i++) begin
            step(1);
            if (flag) seen++;
        end
        check("R5 halts without run bit", seen, 0);
        default_cfg();
    endtask

    task automatic t_irq();
        check("R6 irq low when disabled", irq, 0);
        write_rate(1, 0);
        step(2048);
        check("R6 flag set", flag, 1);
        check("R6 irq gated by enable", irq, 0);
        irq_en = 1'b1;
        step(1);
        check("R6 irq with enable", irq, 1);
        clr_we = 1'b1; clr_wdata = 1'b0;
        step(1);
        clr_we = 1'b0;
        check("R8 write 0 keeps flag", flag, 1);
        clear_flag();
        check("R6 irq drops with flag", irq, 0);
        irq_en = 1'b0;
    endtask

    task automatic t_restart();
        default_cfg();
        clear_flag();
        write_rate(1, 0);
        step(1000);
        write_rate(1, 0);
        expect_expiry("R7 restart on write", 2048);
    endtask

    task automatic t_priority();
        default_cfg();
        clear_flag();
        write_rate(1, 0);
        step(2047);
        check("R9 pre-expiry flag", flag, 0);
        clr_we = 1'b1; clr_wdata = 1'b1;
        step(1);
        clr_we = 1'b0; clr_wdata = 1'b0;
        check("R9 expiry beats clear", flag, 1);
    endtask

    task automatic t_disable();
        int seen = 0;
        default_cfg();
        clear_flag();
        write_rate(0, 5);
        for (int i = 0; i < 3000; i++) begin
            step(1);
            if (flag) seen++;
        end
        check("R10 zero exponent disabled", seen, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_period_restart(1, 0);
        t_period_restart(2, 3);
        t_source();
        t_stop();
        t_pseudo();
        t_irq();
        t_restart();
        t_priority();
        t_disable();
        finish_run();
    end

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule